// File: doc/BRIEF.md
# Strobe-Decoded Byte Memory Front End

This block is a synchronous controller that stands in front of a byte-wide static memory array. Its inputs look like those of a classic asynchronous memory device. Chip select, write strobe and output enable are all active low. It also takes a 19-bit byte address, a write data bus and a protect input. The bidirectional data pins are modelled as a read data output plus a drive-enable output. The block samples every input on each rising clock edge, so all access rules are resolved at clock granularity. Timing limits in nanoseconds become rules about which sampled cycle does what.

A write window opens on the first sampled cycle in which chip select and write strobe are both low. It closes on the first sampled cycle in which either of them has returned high, and the byte is committed in that closing cycle. The address is captured when the window opens. Any change of address while the window is open raises an error flag. After each write, the write strobe must rest high for a number of cycles before a new write window can open. While the protect input is high, every input is ignored and the data pins are not driven. A write that is still open when protect rises is dropped.

The storage holds 2^ARRAY_AW bytes. A full-size array uses ARRAY_AW = 19. Smaller values keep only the low address bits, which suits simulation models.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: When a cycle samples write strobe high, chip select low, output enable low and protect low, the next cycle shows `dout_en` = 1 and `dout` equal to the stored byte at the sampled address.
- R2: For any other sampled combination of the strobes, the next cycle shows `dout_en` = 0 and `dout` = 0.
- R3: A write window opens in a cycle that samples chip select and write strobe both low, with protect low and the recovery rule (R6) met. The address sampled in that cycle is the target.
- R4: The window closes on the first sampled cycle in which chip select or write strobe is high, whichever rises first. That cycle commits the last data byte sampled while both strobes were low.
- R5: If the write strobe falls while the outputs are driven, `dout_en` is 0 in the cycle after the fall is sampled.
- R6: A new window opens only after the write strobe has been sampled high for at least RECOVERY consecutive cycles. A low period of the write strobe that begins too early writes nothing. One low period of the write strobe opens at most one window, even if chip select toggles within it.
- R7: While protect is sampled high, no window opens, no read is served (`dout_en` = 0 on the next cycle), and the stored bytes stay unchanged.
- R8: If protect is sampled high while a window is open, that write is discarded. The target byte keeps its old value.
- R9: If the sampled address differs from the captured target while the window is open, `addr_err` is 1 from the next cycle until the next window opens. The write still goes to the captured target.
- R10: Only the low ARRAY_AW address bits select a byte, so addresses that match in those bits refer to the same byte.
- R11: After reset, `dout_en` = 0, `dout` = 0 and `addr_err` = 0, and the recovery rule counts as already met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| wp | input | 1 | Protect: ignore inputs and stop driving data |
| addr | input | 19 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Data pin drive enable |
| addr_err | output | 1 | Address changed during an open write window |

## Verification
The bench builds the block with ARRAY_AW = 4 and RECOVERY = 3. The small array lets one address differing only in its upper bits exercise aliasing. A three-cycle recovery leaves room to lower the write strobe after only one high cycle and show that this early pulse is rejected. Directed sequences also cover both closing orders of the strobes and data that changes within an open window. They also cover protect raised in the middle of a write and chip select toggling while the write strobe stays low.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;

    localparam int unsigned EXT_AW = 19;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

    function automatic logic both_low(input logic a_n, input logic b_n);
        return !a_n && !b_n;
    endfunction

    function automatic logic read_cycle(input logic ce_n, input logic oe_n,
                                        input logic we_n, input logic prot);
        return !prot && !ce_n && !oe_n && we_n;
    endfunction

endpackage

// File: rtl/sram_fe_recovery.sv
module sram_fe_recovery #(
    parameter int unsigned RECOVERY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic we_n,
    input  logic start,
    output logic gate_ok
);

    generate
        if (RECOVERY == 0) begin : g_no_rest
            always_ff @(posedge clk) begin
                if (rst)        gate_ok <= 1'b1;
                else if (we_n)  gate_ok <= 1'b1;
                else if (start) gate_ok <= 1'b0;
            end
        end else begin : g_rest_count
            localparam int unsigned CW = $clog2(RECOVERY + 1);
            localparam logic [CW-1:0] REC_V = CW'(RECOVERY);
            logic [CW-1:0] hi_cnt;
            logic [CW-1:0] hi_next;

            always_comb begin
                hi_next = (hi_cnt == REC_V) ? hi_cnt : hi_cnt + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    hi_cnt  <= REC_V;
                    gate_ok <= 1'b1;
                end else if (we_n) begin
                    hi_cnt  <= hi_next;
                    gate_ok <= (hi_next == REC_V);
                end else begin
                    hi_cnt  <= '0;
                    if (start) gate_ok <= 1'b0;
                end
            end
        end
    endgenerate

    assert_gate_rearm_high_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_ok) |-> $past(we_n));

endmodule

// File: rtl/sram_fe_write_seq.sv
module sram_fe_write_seq
    import sram_fe_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              wp,
    input  logic              gate_ok,
    input  logic [EXT_AW-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic              start,
    output logic              wr_open,
    output logic              cmt_en,
    output logic [IDX_W-1:0]  cmt_idx,
    output logic [BYTE_W-1:0] cmt_data,
    output logic              addr_err
);

    win_state_t        state;
    logic [EXT_AW-1:0] cap_addr;
    logic [BYTE_W-1:0] cap_data;
    logic              strobes_low;

    always_comb begin
        strobes_low = both_low(ce_n, we_n);
        wr_open     = (state == WIN_OPEN);
        start       = (state == WIN_IDLE) && strobes_low && gate_ok && !wp;
        cmt_en      = wr_open && !wp && !strobes_low;
        cmt_idx     = cap_addr[IDX_W-1:0];
        cmt_data    = cap_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WIN_IDLE;
            cap_addr <= '0;
            cap_data <= '0;
            addr_err <= 1'b0;
        end else begin
            unique case (state)
                WIN_IDLE: begin
                    if (start) begin
                        state    <= WIN_OPEN;
                        cap_addr <= addr;
                        cap_data <= din;
                        addr_err <= 1'b0;
                    end
                end
                WIN_OPEN: begin
                    if (wp || !strobes_low) begin
                        state <= WIN_IDLE;
                    end else begin
                        cap_data <= din;
                        if (addr != cap_addr) addr_err <= 1'b1;
                    end
                end
                default: state <= WIN_IDLE;
            endcase
        end
    end

    assert_open_on_low_strobes_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_open) |-> $past(!ce_n && !we_n && !wp));

    assert_commit_after_window_R4: assert property (@(posedge clk) disable iff (rst)
        cmt_en |-> $past(!ce_n && !we_n));

    assert_err_only_in_window_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_err) |-> $past(wr_open));

endmodule

// File: rtl/sram_fe_array.sv
module sram_fe_array
    import sram_fe_pkg::*;
#(
    parameter int unsigned AW = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_idx,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        rd_data <= rd_en ? mem[rd_idx] : '0;
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_fe_pkg::*;
#(
    parameter int unsigned ARRAY_AW = 10,
    parameter int unsigned RECOVERY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              wp,
    input  logic [EXT_AW-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_en,
    output logic              addr_err
);

    logic              gate_ok;
    logic              start;
    logic              wr_open;
    logic              cmt_en;
    logic [ARRAY_AW-1:0] cmt_idx;
    logic [BYTE_W-1:0] cmt_data;
    logic              rd_go;
    logic [BYTE_W-1:0] rd_data;

    sram_fe_recovery #(.RECOVERY(RECOVERY)) u_rec (
        .clk     (clk),
        .rst     (rst),
        .we_n    (we_n),
        .start   (start),
        .gate_ok (gate_ok)
    );

    sram_fe_write_seq #(.IDX_W(ARRAY_AW)) u_wseq (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .wp       (wp),
        .gate_ok  (gate_ok),
        .addr     (addr),
        .din      (din),
        .start    (start),
        .wr_open  (wr_open),
        .cmt_en   (cmt_en),
        .cmt_idx  (cmt_idx),
        .cmt_data (cmt_data),
        .addr_err (addr_err)
    );

    always_comb rd_go = read_cycle(ce_n, oe_n, we_n, wp);

    sram_fe_array #(.AW(ARRAY_AW)) u_arr (
        .clk     (clk),
        .wr_en   (cmt_en),
        .wr_idx  (cmt_idx),
        .wr_data (cmt_data),
        .rd_en   (rd_go),
        .rd_idx  (addr[ARRAY_AW-1:0]),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) dout_en <= 1'b0;
        else     dout_en <= rd_go;
    end

    always_comb dout = dout_en ? rd_data : '0;

    assert_read_needs_strobes_R1: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> $past(!oe_n && !ce_n && we_n));

    assert_drive_off_on_we_R5: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> !dout_en);

    assert_protect_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        wp |=> !dout_en);

    assert_no_write_in_read_R2: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> !wr_open);

endmodule

// File: tb/tb_sram_strobe_ctrl.sv
module tb_sram_strobe_ctrl;
    import sram_fe_pkg::*;

    localparam int unsigned AAW = 4;
    localparam int unsigned REC = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp = 1'b0;
    logic [EXT_AW-1:0] addr = '0;
    logic [BYTE_W-1:0] din = '0;
    logic [BYTE_W-1:0] dout;
    logic              dout_en;
    logic              addr_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sram_strobe_ctrl #(.ARRAY_AW(AAW), .RECOVERY(REC)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wp(wp),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .addr_err(addr_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rest();
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (REC) @(negedge clk);
    endtask

    task automatic write_byte(input logic [EXT_AW-1:0] a, input logic [BYTE_W-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
        rest();
    endtask

    task automatic read_expect(input logic [EXT_AW-1:0] a, input logic [BYTE_W-1:0] e,
                               input string tag);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk);
        chk(dout_en == 1'b1, tag, dout_en, 1);
        chk(dout == e, tag, dout, e);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_reset();
        chk(dout_en == 1'b0, "R11 drive after reset", dout_en, 0);
        chk(dout == '0, "R11 data after reset", dout, 0);
        chk(addr_err == 1'b0, "R11 error after reset", addr_err, 0);
    endtask

    task automatic t_basic();
        write_byte(19'd1, 8'h5A);
        write_byte(19'd2, 8'hC3);
        read_expect(19'd1, 8'h5A, "R1 R3 read addr 1");
        read_expect(19'd2, 8'hC3, "R1 R4 read addr 2");
    endtask

    task automatic t_no_drive();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 19'd1;
        @(negedge clk);
        chk(dout_en == 1'b0 && dout == '0, "R2 oe high", dout_en, 0);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        chk(dout_en == 1'b0 && dout == '0, "R2 ce high", dout_en, 0);
        oe_n = 1'b1;
    endtask

    task automatic t_we_fall_off();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 19'd1;
        @(negedge clk);
        chk(dout_en == 1'b1, "R5 driving before fall", dout_en, 1);
        we_n = 1'b0; din = 8'h5A;
        @(negedge clk);
        chk(dout_en == 1'b0, "R5 drive off after we fall", dout_en, 0);
        oe_n = 1'b1;
        rest();
        read_expect(19'd1, 8'h5A, "R5 byte intact");
    endtask

    task automatic t_data_late();
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 19'd4; din = 8'h11;
        @(negedge clk);
        din = 8'h22;
        @(negedge clk);
        ce_n = 1'b1; din = 8'h99;
        @(negedge clk);
        rest();
        read_expect(19'd4, 8'h22, "R4 ce-first close keeps last data");
    endtask

    task automatic t_one_per_low();
        write_byte(19'd6, 8'h66);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 19'd5; din = 8'h33;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0; addr = 19'd6; din = 8'h44;
        @(negedge clk);
        rest();
        read_expect(19'd5, 8'h33, "R6 first window written");
        read_expect(19'd6, 8'h66, "R6 second ce pulse ignored");
    endtask

    task automatic t_early();
        write_byte(19'd7, 8'h70);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 19'd8; din = 8'h81;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 19'd7; din = 8'h99;
        @(negedge clk);
        @(negedge clk);
        rest();
        read_expect(19'd7, 8'h70, "R6 early pulse rejected");
        read_expect(19'd8, 8'h81, "R6 prior write kept");
    endtask

    task automatic t_protect();
        write_byte(19'd9, 8'h90);
        @(negedge clk);
        wp = 1'b1; ce_n = 1'b0; we_n = 1'b0; addr = 19'd9; din = 8'hAA;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (REC) @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk(dout_en == 1'b0, "R7 no read while protected", dout_en, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        wp = 1'b0;
        read_expect(19'd9, 8'h90, "R7 write ignored while protected");
    endtask

    task automatic t_abort();
        write_byte(19'd10, 8'hA0);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 19'd10; din = 8'hBB;
        @(negedge clk);
        wp = 1'b1;
        @(negedge clk);
        wp = 1'b0;
        @(negedge clk);
        rest();
        read_expect(19'd10, 8'hA0, "R8 aborted write not committed");
    endtask

    task automatic t_addr_err();
        write_byte(19'd12, 8'hC0);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = 19'd11; din = 8'hB1;
        @(negedge clk);
        chk(addr_err == 1'b0, "R9 no error at open", addr_err, 0);
        addr = 19'd12;
        @(negedge clk);
        chk(addr_err == 1'b1, "R9 error on address change", addr_err, 1);
        rest();
        chk(addr_err == 1'b1, "R9 error held after close", addr_err, 1);
        read_expect(19'd11, 8'hB1, "R9 write to captured address");
        read_expect(19'd12, 8'hC0, "R9 changed address untouched");
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 19'd13; din = 8'hD1;
        @(negedge clk);
        chk(addr_err == 1'b0, "R9 error cleared at next open", addr_err, 0);
        rest();
    endtask

    task automatic t_alias();
        write_byte(19'h13, 8'h5C);
        read_expect(19'h3, 8'h5C, "R10 low bits select byte");
        read_expect(19'h40003, 8'h5C, "R10 top bit ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_no_drive();
        t_we_fall_off();
        t_data_late();
        t_one_per_low();
        t_early();
        t_protect();
        t_abort();
        t_addr_err();
        t_alias();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule